// File: doc/BRIEF.md
# Instruction Execute and Writeback Unit

This block is the execute stage of a small processor with 16-bit instructions and four operations: add, two's-complement negate, load immediate and jump-if-zero. It receives the instruction word and the two 32-bit operand values that the register file has already read for the instruction's first and second source fields. It produces one common result bundle for every operation: a jump flag, a 32-bit result value, a 3-bit destination register index and a write enable. The 8-bit jump target is also passed out.

The caller feeds the write enable, index and value into the register file's write port. It feeds the jump flag and target into the program-counter logic. Every output is registered, so the bundle for an instruction shows up one clock after it is presented. A synchronous active-high reset clears the whole bundle. Register storage and program-counter sequencing sit outside this block.

Bit positions below use the instruction word `instr[15:0]`. The opcode occupies `instr[15:14]`, with `instr[15]` as its first bit. The first source field is `instr[13:11]`, the second source field is `instr[10:8]`, the add destination field is `instr[7:5]`, and the 8-bit constant is `instr[7:0]`. Each field is read MSB first, so a first source field of `010` names register 2.

Top module: `exu_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output becomes 0 after that edge.
- R2: Outputs after a rising edge (with `rst` low) depend only on `instr`, `ra_val` and `rb_val` sampled at that edge. Latency is one cycle.
- R3: Opcode `00` (add): `val_o` = (`ra_val` + `rb_val`) mod 2^32, `dst_o` = `instr[7:5]`, `wen_o` = 1, `jump_o` = 0.
- R4: Opcode `01` (negate): `val_o` = (invert `ra_val`, then add 1) mod 2^32, `dst_o` = `instr[13:11]`, `wen_o` = 1, `jump_o` = 0. For example, 0 gives 0 and 0x80000000 gives 0x80000000.
- R5: Opcode `10` (load immediate): `val_o` = `instr[7:0]` zero-extended to 32 bits, `dst_o` = `instr[13:11]`, `wen_o` = 1, `jump_o` = 0.
- R6: Opcode `11` (jump-if-zero): `jump_o` = 1 exactly when `ra_val` is 0, and `wen_o`, `val_o` and `dst_o` are all 0.
- R7: `target_o` equals `instr[7:0]` for every opcode.
- R8: `rb_val` has no effect on the outputs of negate, load immediate or jump-if-zero. `ra_val` has no effect on the outputs of load immediate.
- R9: `jump_o` and `wen_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word |
| ra_val | input | 32 | Value of the register named by the first source field |
| rb_val | input | 32 | Value of the register named by the second source field |
| jump_o | output | 1 | Take the jump |
| val_o | output | 32 | Value to be written |
| dst_o | output | 3 | Destination register index |
| wen_o | output | 1 | Register write enable |
| target_o | output | 8 | Jump target constant |

## Verification
The bench goes through all 65,536 instruction words. Each word is driven twice, with the second source value changed between the two runs, and the source values are mixed with zero, all-ones and sign-bit-only patterns.

Each corner case catches a specific fault:
- A design that takes the destination from the wrong field writes the wrong register. Swapping the add destination with the source field is one way to do this.
- A negate that inverts but never adds one is off by one on every value.
- A negate with an extra term fails on 0 and on 0x80000000.
- A load immediate that sign-extends sets the upper bits for constants of 0x80 and above.
- A jump-if-zero that tests only some of the bits jumps on nonzero values with low bits clear.
- A jump that still asserts its write enable corrupts a register.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int XLEN   = 32;
  localparam int IW     = 16;
  localparam int RIDX_W = 3;
  localparam int IMM_W  = 8;
  localparam int OPC_W  = 2;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD = 2'b00,
    OP_NEG = 2'b01,
    OP_LDI = 2'b10,
    OP_JZ  = 2'b11
  } opc_e;
endpackage

// File: rtl/exu_fields.sv
module exu_fields
  import exu_pkg::*;
#(
  parameter int IW_P     = IW,
  parameter int RIDX_W_P = RIDX_W,
  parameter int IMM_W_P  = IMM_W
) (
  input  logic [IW_P-1:0]     instr,
  output opc_e                opc,
  output logic [RIDX_W_P-1:0] src_a,
  output logic [RIDX_W_P-1:0] dst_c,
  output logic [IMM_W_P-1:0]  imm
);
  // Field placement counted from the opcode end of the word.
  localparam int A_HI = IW_P - 1 - OPC_W;
  localparam int B_HI = A_HI - RIDX_W_P;
  localparam int C_HI = B_HI - RIDX_W_P;

  assign opc   = opc_e'(instr[IW_P-1 -: OPC_W]);
  assign src_a = instr[A_HI -: RIDX_W_P];
  assign dst_c = instr[C_HI -: RIDX_W_P];
  assign imm   = instr[IMM_W_P-1:0];
endmodule

// File: rtl/exu_adder.sv
module exu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  logic [W:0] cy;
  assign cy[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic p;
    assign p         = a[i] ^ b[i];
    assign sum[i]    = p ^ cy[i];
    assign cy[i+1]   = (a[i] & b[i]) | (p & cy[i]);
  end
endmodule

// File: rtl/exu_pick.sv
module exu_pick
  import exu_pkg::*;
#(
  parameter int XLEN_P   = XLEN,
  parameter int RIDX_W_P = RIDX_W,
  parameter int IMM_W_P  = IMM_W
) (
  input  opc_e                opc,
  input  logic [XLEN_P-1:0]   sum_ab,
  input  logic [XLEN_P-1:0]   neg_a,
  input  logic [IMM_W_P-1:0]  imm,
  input  logic                a_zero,
  input  logic [RIDX_W_P-1:0] src_a,
  input  logic [RIDX_W_P-1:0] dst_c,
  output logic                nxt_jump,
  output logic [XLEN_P-1:0]   nxt_val,
  output logic [RIDX_W_P-1:0] nxt_dst,
  output logic                nxt_wen
);
  localparam int PAD_W = XLEN_P - IMM_W_P;

  always_comb begin
    nxt_jump = 1'b0;
    nxt_val  = '0;
    nxt_dst  = '0;
    nxt_wen  = 1'b0;
    unique case (opc)
      OP_ADD: begin
        nxt_val = sum_ab;
        nxt_dst = dst_c;
        nxt_wen = 1'b1;
      end
      OP_NEG: begin
        nxt_val = neg_a;
        nxt_dst = src_a;
        nxt_wen = 1'b1;
      end
      OP_LDI: begin
        nxt_val = {{PAD_W{1'b0}}, imm};
        nxt_dst = src_a;
        nxt_wen = 1'b1;
      end
      OP_JZ: begin
        nxt_jump = a_zero;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int XLEN_P   = XLEN,
  parameter int IW_P     = IW,
  parameter int RIDX_W_P = RIDX_W,
  parameter int IMM_W_P  = IMM_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IW_P-1:0]     instr,
  input  logic [XLEN_P-1:0]   ra_val,
  input  logic [XLEN_P-1:0]   rb_val,
  output logic                jump_o,
  output logic [XLEN_P-1:0]   val_o,
  output logic [RIDX_W_P-1:0] dst_o,
  output logic                wen_o,
  output logic [IMM_W_P-1:0]  target_o
);
  opc_e                opc;
  logic [RIDX_W_P-1:0] src_a, dst_c;
  logic [IMM_W_P-1:0]  imm;
  logic [XLEN_P-1:0]   sum_ab, neg_a;
  logic                a_zero;
  logic                nxt_jump, nxt_wen;
  logic [XLEN_P-1:0]   nxt_val;
  logic [RIDX_W_P-1:0] nxt_dst;

  exu_fields #(.IW_P(IW_P), .RIDX_W_P(RIDX_W_P), .IMM_W_P(IMM_W_P)) u_fields (
    .instr(instr), .opc(opc), .src_a(src_a), .dst_c(dst_c), .imm(imm)
  );

  // Sum of both sources.
  exu_adder #(.W(XLEN_P)) u_add (
    .a(ra_val), .b(rb_val), .cin(1'b0), .sum(sum_ab)
  );

  // Negation: inverted source plus one through the carry input.
  exu_adder #(.W(XLEN_P)) u_neg (
    .a(~ra_val), .b({XLEN_P{1'b0}}), .cin(1'b1), .sum(neg_a)
  );

  assign a_zero = ~|ra_val;

  exu_pick #(.XLEN_P(XLEN_P), .RIDX_W_P(RIDX_W_P), .IMM_W_P(IMM_W_P)) u_pick (
    .opc(opc), .sum_ab(sum_ab), .neg_a(neg_a), .imm(imm), .a_zero(a_zero),
    .src_a(src_a), .dst_c(dst_c),
    .nxt_jump(nxt_jump), .nxt_val(nxt_val), .nxt_dst(nxt_dst), .nxt_wen(nxt_wen)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      jump_o   <= 1'b0;
      val_o    <= '0;
      dst_o    <= '0;
      wen_o    <= 1'b0;
      target_o <= '0;
    end else begin
      jump_o   <= nxt_jump;
      val_o    <= nxt_val;
      dst_o    <= nxt_dst;
      wen_o    <= nxt_wen;
      target_o <= imm;
    end
  end
endmodule

// File: rtl/exu_core_chk.sv
module exu_core_chk #(
  parameter int XLEN_P   = 32,
  parameter int IW_P     = 16,
  parameter int RIDX_W_P = 3,
  parameter int IMM_W_P  = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [IW_P-1:0]     instr,
  input logic [XLEN_P-1:0]   ra_val,
  input logic [XLEN_P-1:0]   rb_val,
  input logic                jump_o,
  input logic [XLEN_P-1:0]   val_o,
  input logic [RIDX_W_P-1:0] dst_o,
  input logic                wen_o,
  input logic [IMM_W_P-1:0]  target_o
);
  logic rst_q;
  logic live;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    live  <= !rst;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst_q |-> (!jump_o && !wen_o && val_o == '0 && dst_o == '0 && target_o == '0));

  assert_add_sum_R3: assert property (@(posedge clk) disable iff (rst)
    (live && $past(instr[IW_P-1 -: 2]) == 2'b00)
      |-> (wen_o && !jump_o && val_o == $past(ra_val) + $past(rb_val)));

  assert_neg_cancels_R4: assert property (@(posedge clk) disable iff (rst)
    (live && $past(instr[IW_P-1 -: 2]) == 2'b01)
      |-> (wen_o && !jump_o && val_o + $past(ra_val) == '0));

  assert_ldi_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (live && $past(instr[IW_P-1 -: 2]) == 2'b10)
      |-> (wen_o && !jump_o && val_o[XLEN_P-1:IMM_W_P] == '0));

  assert_jz_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (live && $past(instr[IW_P-1 -: 2]) == 2'b11)
      |-> (!wen_o && jump_o == ($past(ra_val) == '0)));

  assert_target_pass_R7: assert property (@(posedge clk) disable iff (rst)
    live |-> target_o == $past(instr[IMM_W_P-1:0]));

  assert_jump_write_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(jump_o && wen_o));
endmodule

bind exu_core exu_core_chk #(
  .XLEN_P(XLEN_P), .IW_P(IW_P), .RIDX_W_P(RIDX_W_P), .IMM_W_P(IMM_W_P)
) u_chk (
  .clk(clk), .rst(rst), .instr(instr), .ra_val(ra_val), .rb_val(rb_val),
  .jump_o(jump_o), .val_o(val_o), .dst_o(dst_o), .wen_o(wen_o), .target_o(target_o)
);

// File: tb/exu_core_test.sv
module exu_core_test;
  localparam int CLK_P = 10;
  localparam int WATCHDOG = 180000;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] instr;
  logic [31:0] ra_val, rb_val;
  logic        jump_o, wen_o;
  logic [31:0] val_o;
  logic [2:0]  dst_o;
  logic [7:0]  target_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  exu_core uut (
    .clk(clk), .rst(rst), .instr(instr), .ra_val(ra_val), .rb_val(rb_val),
    .jump_o(jump_o), .val_o(val_o), .dst_o(dst_o), .wen_o(wen_o), .target_o(target_o)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  task automatic finish_up();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    wait (cycles >= WATCHDOG);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, cycles actual %0d expected below %0d", cycles, WATCHDOG);
    finish_up();
  end

  // Bundle layout: {jump, val, dst, wen, target}
  function automatic logic [44:0] expect_of(input logic [15:0] ins,
                                            input logic [31:0] a, input logic [31:0] b);
    logic [1:0]  op  = ins[15:14];
    logic [2:0]  fa  = ins[13:11];
    logic [2:0]  fc  = ins[7:5];
    logic [7:0]  d   = ins[7:0];
    logic        j   = 1'b0;
    logic [31:0] v   = 32'd0;
    logic [2:0]  i   = 3'd0;
    logic        e   = 1'b0;
    case (op)
      2'b00: begin v = a + b; i = fc; e = 1'b1; end             // R3
      2'b01: begin v = 32'd0 - a; i = fa; e = 1'b1; end         // R4
      2'b10: begin v = {24'd0, d}; i = fa; e = 1'b1; end        // R5
      default: begin j = (a == 32'd0); end                      // R6
    endcase
    return {j, v, i, e, d};                                     // R7
  endfunction

  task automatic check(input string req, input logic [44:0] exp);
    logic [44:0] act = {jump_o, val_o, dst_o, wen_o, target_o};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: instr=%h ra=%h rb=%h actual=%h expected=%h",
               req, instr, ra_val, rb_val, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [15:0] ins);
    case (ins[15:14])
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Drive at a falling edge, sample at the next falling edge (one register, R2).
  task automatic run(input logic [15:0] ins, input logic [31:0] a,
                     input logic [31:0] b, input string req);
    instr = ins; ra_val = a; rb_val = b;
    @(negedge clk);
    check(req, expect_of(ins, a, b));
  endtask

  initial begin
    rst = 1'b1; instr = 16'h0000; ra_val = 32'h1234_5678; rb_val = 32'h9abc_def0;
    @(negedge clk); @(negedge clk);
    check("R1", 45'd0);
    rst = 1'b0;

    // Directed corners
    run(16'b00_001_010_011_00000, 32'hffff_ffff, 32'd1, "R3");  // wraps to 0
    run(16'b01_101_000_00000000, 32'd0, 32'hdead_beef, "R4");
    run(16'b01_110_000_00000000, 32'h8000_0000, 32'd5, "R4");
    run(16'b01_011_000_00000000, 32'd1, 32'd0, "R4");
    run(16'b10_100_000_10000000, 32'hffff_ffff, 32'd0, "R5");   // no sign extension
    run(16'b11_010_000_11111011, 32'd0, 32'hffff_ffff, "R6");
    run(16'b11_010_000_11111011, 32'h0001_0000, 32'd0, "R6");
    run(16'b11_010_000_00000011, 32'h8000_0000, 32'd0, "R9");
    run(16'b00_111_111_101_11111, 32'h7fff_ffff, 32'd1, "R7");

    // Reset in the middle of a run
    instr = 16'b10_001_000_01010101; rst = 1'b1;
    @(negedge clk);
    check("R1", 45'd0);
    rst = 1'b0;

    // Sweep every instruction word, twice with a different rb (R8)
    for (int w = 0; w < 65536; w++) begin
      logic [15:0] ins = w[15:0];
      logic [31:0] a, b;
      case (w % 5)
        0: a = 32'd0;
        1: a = 32'hffff_ffff;
        2: a = 32'h8000_0000;
        default: a = (w * 32'h9e37_79b9) ^ (w << 7);
      endcase
      b = (w * 32'h85eb_ca6b) + 32'h1357;
      run(ins, a, b, tag_of(ins));
      if (ins[15:14] == 2'b00)
        run(ins, a, ~b, "R3");
      else if (ins[15:14] == 2'b10)
        run(ins, ~a, ~b, "R8");   // both sources ignored
      else
        run(ins, a, ~b, "R8");    // rb ignored
    end

    finish_up();
  end
endmodule